// File: doc/BRIEF.md
# Cascaded TDM Frame Sync Generator

This block produces the framing for a chain of codec devices that share one serial data line and one bit clock. The first device is framed by a primary sync. Every later device gets its own delayed sync, which is raised once the two 16-bit slots of the device before it have gone by. A frame begins with a data phase of two slots per device. In programming mode a control phase of the same length follows the data phase. Control slots are never mixed in among the data slots.

The bit clock may be gapped: some of its pulses can be missing, so the slot boundaries are not evenly spaced in time. For this reason the block never measures time. It advances only on a one-cycle bit-clock enable `bclk_en`, and every position is a count of those enables. The device count and the mode are sampled while reset is held and stay fixed until the next reset.

The controller has three states:
- `ST_IDLE` is the state after reset. It moves to `ST_DATA` on the first enable, and that enable starts a frame.
- `ST_DATA` moves to `ST_CTRL` at the end of the last data slot when programming mode is set. When programming mode is clear it stays in `ST_DATA` and starts a new frame.
- `ST_CTRL` moves back to `ST_DATA` at the end of the last control slot.

Top module: `tdm_chain_sync`

## Requirements
- R1: After reset, and until the first enable with `rst_n` high, every sync is inactive, `slot_idx_o` is 0, and both phase flags are 0. That first enable makes bit 0 of slot 0 of the first frame current.
- R2: `fs_o` is active for exactly one enable interval, at bit 0 of slot 0 of each frame, and is inactive at every other position.
- R3: A frame lasts 16 × 2 × N × M enables, where N is the latched device count and M is 2 in programming mode and 1 otherwise. Consecutive `fs_o` assertions are exactly that many enables apart.
- R4: `slot_idx_o` advances by one after every 16 enables. It runs from 0 to 2N−1 in data-only mode and from 0 to 4N−1 in programming mode, then returns to 0.
- R5: `data_phase_o` is 1 during slots 0 to 2N−1. `ctrl_phase_o` is 1 during slots 2N to 4N−1, and only in programming mode. The two flags are never 1 together.
- R6: `fsd_o[j]` is the sync of device j+2 (j from 0 to 6). It is active for one enable interval at bit 0 of slot 2(j+1), which is 32(j+1) enables after `fs_o`, and only when j+1 < N. It is never active in the control phase, and it stays inactive for j+1 ≥ N.
- R7: A clock cycle without `bclk_en` leaves every output unchanged, so any pattern of gaps in the bit clock yields the same sequence of outputs per enable.
- R8: `dev_count` and `prog_mode` are sampled only while `rst_n` is low. A `dev_count` of 0 is taken as 1, and a value above 8 is taken as 8. Changes to either input while `rst_n` is high have no effect.
- R9: With `FS_ACTIVE_HIGH` = 0, `fs_o` and `fsd_o` have the inverse of their active-high levels on every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; `dev_count` and `prog_mode` are sampled while it is low |
| bclk_en | input | 1 | One-cycle pulse per emitted bit clock |
| dev_count | input | 4 | Number of devices in the chain (1 to 8) |
| prog_mode | input | 1 | 1 = programming mode (data phase plus control phase); 0 = data phase only |
| fs_o | output | 1 | Primary frame sync |
| fsd_o | output | 7 | Delayed syncs; bit j belongs to device j+2 |
| slot_idx_o | output | 5 | Index of the current slot within the frame |
| data_phase_o | output | 1 | The current slot is a data slot |
| ctrl_phase_o | output | 1 | The current slot is a control slot |

## Verification
A wrong bit or slot count shows up at the ports on the very next enable: `slot_idx_o` steps at the wrong point, and `fs_o` or one of the delayed syncs lands at the wrong position. The spacing between frame syncs then differs from the expected frame length within one frame. A controller stuck in the wrong state shows up as phase flags that disagree with the slot index at the first phase boundary. A missed hold during a clock gap changes the outputs in a cycle that has no enable, so the gapped-clock patterns expose it at once.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CTRL = 2'd2
    } chain_state_e;
endpackage

// File: rtl/tdm_sync_cfg.sv
module tdm_sync_cfg #(
    parameter int MAX_DEV       = 8,
    parameter int SLOTS_PER_DEV = 2,
    parameter int DEV_W         = 4,
    parameter int SLOT_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_count_i,
    input  logic              prog_mode_i,
    output logic [DEV_W-1:0]  ndev_o,
    output logic              prog_o,
    output logic [SLOT_W-1:0] data_last_o,
    output logic [SLOT_W-1:0] frame_last_o
);
    logic [DEV_W-1:0]  clamp_cnt;
    logic [DEV_W-1:0]  ndev_q;
    logic              prog_q;
    logic [SLOT_W-1:0] data_slots;

    // out-of-range counts are forced into 1..MAX_DEV
    always_comb begin
        if (dev_count_i == '0)
            clamp_cnt = DEV_W'(1);
        else if (dev_count_i > DEV_W'(MAX_DEV))
            clamp_cnt = DEV_W'(MAX_DEV);
        else
            clamp_cnt = dev_count_i;
    end

    // sampled only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ndev_q <= clamp_cnt;
            prog_q <= prog_mode_i;
        end
    end

    always_comb begin
        data_slots   = SLOT_W'(ndev_q) * SLOT_W'(SLOTS_PER_DEV);
        data_last_o  = data_slots - SLOT_W'(1);
        frame_last_o = prog_q ? (SLOT_W'(2) * data_slots - SLOT_W'(1)) : data_last_o;
        ndev_o       = ndev_q;
        prog_o       = prog_q;
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(ndev_q) && $stable(prog_q))); // R8
    AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ndev_q >= DEV_W'(1)) && (ndev_q <= DEV_W'(MAX_DEV))); // R8
endmodule

// File: rtl/tdm_sync_counter.sv
module tdm_sync_counter #(
    parameter int SLOT_BITS = 16,
    parameter int BIT_W     = 4,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [SLOT_W-1:0] frame_last_i,
    output logic [BIT_W-1:0]  bit_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              bit_last_o,
    output logic              frame_end_o
);
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;

    assign bit_last_o  = (bit_q == BIT_W'(SLOT_BITS - 1));
    assign frame_end_o = bit_last_o && (slot_q == frame_last_i);
    assign bit_o       = bit_q;
    assign slot_o      = slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (step_i) begin
            if (bit_last_o) begin
                bit_q  <= '0;
                slot_q <= (slot_q == frame_last_i) ? '0 : slot_q + SLOT_W'(1);
            end else begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(bit_q) && $stable(slot_q))); // R7
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= frame_last_i); // R4
endmodule

// File: rtl/tdm_sync_decode.sv
module tdm_sync_decode #(
    parameter int MAX_DEV       = 8,
    parameter int SLOTS_PER_DEV = 2,
    parameter int DEV_W         = 4,
    parameter int SLOT_W        = 5,
    parameter int BIT_W         = 4
) (
    input  logic               data_phase_i,
    input  logic [BIT_W-1:0]   bit_i,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic [DEV_W-1:0]   ndev_i,
    output logic [MAX_DEV-2:0] fsd_o
);
    logic slot_start;
    assign slot_start = data_phase_i && (bit_i == '0);

    // device k+1 is framed once devices 0..k-1 have used their slots
    for (genvar k = 1; k < MAX_DEV; k++) begin : g_dev
        assign fsd_o[k-1] = slot_start
                         && (slot_i == SLOT_W'(SLOTS_PER_DEV * k))
                         && (DEV_W'(k) < ndev_i);
    end
endmodule

// File: rtl/tdm_chain_sync.sv
module tdm_chain_sync #(
    parameter int MAX_DEV        = 8,
    parameter int SLOT_BITS      = 16,
    parameter int SLOTS_PER_DEV  = 2,
    parameter bit FS_ACTIVE_HIGH = 1'b1
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        bclk_en,
    input  logic [$clog2(MAX_DEV+1)-1:0]                dev_count,
    input  logic                                        prog_mode,
    output logic                                        fs_o,
    output logic [MAX_DEV-2:0]                          fsd_o,
    output logic [$clog2(SLOTS_PER_DEV*MAX_DEV*2)-1:0]  slot_idx_o,
    output logic                                        data_phase_o,
    output logic                                        ctrl_phase_o
);
    import tdm_sync_pkg::*;

    localparam int DEV_W  = $clog2(MAX_DEV + 1);
    localparam int SLOT_W = $clog2(SLOTS_PER_DEV * MAX_DEV * 2);
    localparam int BIT_W  = $clog2(SLOT_BITS);

    chain_state_e      state_q, state_d;
    logic [DEV_W-1:0]  ndev;
    logic              prog;
    logic [SLOT_W-1:0] data_last, frame_last;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              bit_last, frame_end, step;
    logic              in_data, in_ctrl, fs_raw;
    logic [MAX_DEV-2:0] fsd_raw;

    tdm_sync_cfg #(
        .MAX_DEV(MAX_DEV), .SLOTS_PER_DEV(SLOTS_PER_DEV),
        .DEV_W(DEV_W), .SLOT_W(SLOT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .dev_count_i(dev_count), .prog_mode_i(prog_mode),
        .ndev_o(ndev), .prog_o(prog),
        .data_last_o(data_last), .frame_last_o(frame_last)
    );

    assign step = bclk_en && (state_q != ST_IDLE);

    tdm_sync_counter #(
        .SLOT_BITS(SLOT_BITS), .BIT_W(BIT_W), .SLOT_W(SLOT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(step),
        .frame_last_i(frame_last),
        .bit_o(bit_idx), .slot_o(slot_idx),
        .bit_last_o(bit_last), .frame_end_o(frame_end)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bclk_en) state_d = ST_DATA;
            ST_DATA: if (bclk_en && bit_last && (slot_idx == data_last))
                         state_d = prog ? ST_CTRL : ST_DATA;
            ST_CTRL: if (bclk_en && frame_end) state_d = ST_DATA;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_data = 1'b0;
        in_ctrl = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DATA: in_data = 1'b1;
            ST_CTRL: in_ctrl = 1'b1;
            default: ;
        endcase
        fs_raw = in_data && (slot_idx == '0) && (bit_idx == '0);
    end

    tdm_sync_decode #(
        .MAX_DEV(MAX_DEV), .SLOTS_PER_DEV(SLOTS_PER_DEV),
        .DEV_W(DEV_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
    ) u_dec (
        .data_phase_i(in_data), .bit_i(bit_idx), .slot_i(slot_idx),
        .ndev_i(ndev), .fsd_o(fsd_raw)
    );

    assign fs_o         = FS_ACTIVE_HIGH ? fs_raw  : ~fs_raw;
    assign fsd_o        = FS_ACTIVE_HIGH ? fsd_raw : ~fsd_raw;
    assign slot_idx_o   = slot_idx;
    assign data_phase_o = in_data;
    assign ctrl_phase_o = in_ctrl;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> ((slot_idx == '0) && (bit_idx == '0))); // R1
    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_raw && bclk_en) |=> !fs_raw); // R2
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_data && in_ctrl)); // R5
    AST_CTRL_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        !prog |-> (state_q != ST_CTRL)); // R5
    AST_DATA_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |-> (slot_idx <= data_last)); // R5
    AST_CTRL_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ctrl |-> (slot_idx > data_last)); // R5
    AST_SYNC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fs_raw, fsd_raw})); // R6
endmodule

// File: tb/test_tdm_chain_sync.sv
module test_tdm_chain_sync;
    typedef struct packed {
        logic       fs;
        logic [6:0] fsd;
        logic [4:0] slot;
        logic       data;
        logic       ctrl;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_en = 1'b0;
    logic [3:0] dev_count = 4'd3;
    logic       prog_mode = 1'b1;
    logic       fs_o, data_phase_o, ctrl_phase_o;
    logic [6:0] fsd_o;
    logic [4:0] slot_idx_o;
    logic       fs_lo, dp_lo, cp_lo;
    logic [6:0] fsd_lo;
    logic [4:0] slot_lo;

    int tests = 0, fails = 0;
    bit done = 0;

    exp_t exp_q[$];
    exp_t cur;
    bit   armed = 0, was_en = 0, started = 0, seen_fs = 0;
    int   nd_m = 1, pos_m = 0, len_m = 32, fs_gap = 0;
    bit   prog_m = 0;
    string seg = "init";

    always #2 clk = ~clk;

    tdm_chain_sync i_tdm_chain_sync (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
        .dev_count(dev_count), .prog_mode(prog_mode),
        .fs_o(fs_o), .fsd_o(fsd_o), .slot_idx_o(slot_idx_o),
        .data_phase_o(data_phase_o), .ctrl_phase_o(ctrl_phase_o)
    );

    tdm_chain_sync #(.FS_ACTIVE_HIGH(1'b0)) i_tdm_chain_sync_low (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en),
        .dev_count(dev_count), .prog_mode(prog_mode),
        .fs_o(fs_lo), .fsd_o(fsd_lo), .slot_idx_o(slot_lo),
        .data_phase_o(dp_lo), .ctrl_phase_o(cp_lo)
    );

    function automatic exp_t model_at(int p);
        exp_t e;
        int s, b;
        s = p / 16;
        b = p % 16;
        e.slot = 5'(s);
        e.data = (s < 2 * nd_m);
        e.ctrl = !e.data;
        e.fs   = (p == 0);
        for (int j = 0; j < 7; j++)
            e.fsd[j] = e.data && (b == 0) && (s == 2 * (j + 1)) && ((j + 1) < nd_m);
        return e;
    endfunction

    // driver: one item per enable
    task automatic drive(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            bit en;
            en = (pat == 0) ? 1'b1 : (pat == 1) ? (i % 3 == 0) : ((i % 16) < 12);
            @(posedge clk);
            #1;
            bclk_en = en;
            if (en) begin
                if (!started) begin started = 1; pos_m = 0; end
                else pos_m = (pos_m + 1) % len_m;
                exp_q.push_back(model_at(pos_m));
            end
        end
        @(posedge clk);
        #1;
        bclk_en = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] dc, input logic pm, input string name);
        @(posedge clk);
        #1;
        seg = name;
        bclk_en = 1'b0;
        dev_count = dc;
        prog_mode = pm;
        rst_n = 1'b0;
        nd_m = (dc == 0) ? 1 : (dc > 8) ? 8 : int'(dc);
        prog_m = pm;
        len_m = 32 * nd_m * (pm ? 2 : 1);
        started = 0;
        exp_q.delete();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (4) @(posedge clk); // idle window, R1
    endtask

    // monitor: pop on each consumed enable
    always @(posedge clk) begin
        armed = 1;
        if (!rst_n) begin
            cur = '0;
            was_en = 0;
            seen_fs = 0;
        end else if (bclk_en) begin
            was_en = 1;
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R3 [%s] enable with no expected item, got none expected one", seg);
            end else cur = exp_q.pop_front();
        end else was_en = 0;
    end

    always @(negedge clk) begin
        if (armed) begin
            string tag;
            exp_t act;
            act = '{fs: fs_o, fsd: fsd_o, slot: slot_idx_o, data: data_phase_o, ctrl: ctrl_phase_o};
            tests++;
            if (act !== cur) begin
                fails++;
                if (!rst_n || !started)      tag = "R1";
                else if (!was_en)            tag = "R7";
                else if (act.fs !== cur.fs)  tag = "R2";
                else if (act.slot !== cur.slot) tag = "R4";
                else if (act.fsd !== cur.fsd)   tag = "R6";
                else                         tag = "R5";
                $display("FAIL %s [%s] got fs=%b fsd=%b slot=%0d d=%b c=%b expected fs=%b fsd=%b slot=%0d d=%b c=%b",
                         tag, seg, act.fs, act.fsd, act.slot, act.data, act.ctrl,
                         cur.fs, cur.fsd, cur.slot, cur.data, cur.ctrl);
            end
            tests++;
            if ({fs_lo, fsd_lo} !== ~{fs_o, fsd_o}) begin
                fails++;
                $display("FAIL R9 [%s] got low-polarity %b expected %b", seg, {fs_lo, fsd_lo}, ~{fs_o, fsd_o});
            end
            if (rst_n && was_en) begin
                if (fs_o === 1'b1) begin
                    if (seen_fs) begin
                        tests++;
                        if (fs_gap != len_m) begin
                            fails++;
                            $display("FAIL R3 [%s] frame length got %0d expected %0d", seg, fs_gap, len_m);
                        end
                    end
                    seen_fs = 1;
                    fs_gap = 1;
                end else fs_gap++;
            end
        end
    end

    initial begin
        do_reset(4'd3, 1'b1, "R4 three devices programming");
        drive(400, 0);
        drive(400, 2);
        drive(300, 1);
        do_reset(4'd1, 1'b0, "R5 one device data only");
        drive(100, 0);
        do_reset(4'd8, 1'b1, "R6 eight devices");
        drive(1100, 0);
        do_reset(4'd0, 1'b1, "R8 zero clamps to one");
        drive(150, 2);
        do_reset(4'd12, 1'b0, "R8 twelve clamps to eight");
        drive(600, 1);
        do_reset(4'd2, 1'b1, "R8 inputs changed after reset");
        dev_count = 4'd7;
        prog_mode = 1'b0;
        drive(300, 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog (all) got hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule